// File: doc/BRIEF.md
# Dual-Path Voltage Error Processor

This block sits between the output-voltage ADC of a digitally controlled buck converter and its two control loops. Each valid ADC sample is subtracted from a reference word to form a signed error. That single error feeds two paths that run side by side.

The slow path sums consecutive errors in non-overlapping windows of N samples, where N is a power of two chosen by a decimation setting. It emits one window mean per N samples for the on-time regulator. The fast path handles every sample. It suppresses errors whose magnitude lies inside a programmable dead band, measured in ADC codes. Errors outside the band are multiplied by an unsigned gain and the product is clipped to the output word, giving an off-time correction.

Top module: `dual_err_proc`

## Requirements
- R1: For each sample accepted with `adc_vld_i` high, the error is `ref_i - adc_i`, with both inputs read as unsigned and the result held as a signed value one bit wider than the ADC word.
- R2: The window size is N = 2^s, where s is `dec_sel_i` clamped to LOG2N_MAX. Each averaged output equals the sum of the N errors in its window shifted right arithmetically by s, which is a floor division.
- R3: `avg_vld_o` pulses for one cycle per window, two clock edges after the edge that accepts the window's last sample. It stays low for every other sample and in every idle cycle.
- R4: `dec_sel_i` is sampled only with the first sample of a window. Changing it in the middle of a window does not change that window's length or its shift.
- R5: Every accepted sample makes `corr_vld_o` pulse for one cycle, two clock edges after the accepting edge, with no decimation.
- R6: When the error e satisfies -`dz_thr_i` <= e <= `dz_thr_i`, `corr_o` is zero.
- R7: Outside the dead band, `corr_o` equals e times `gain_i`, with the gain read as unsigned.
- R8: A product above 2^(OUT_W-1)-1 or below -2^(OUT_W-1) is clipped to that limit, so the correction keeps the sign of the error and never wraps.
- R9: After reset both valid strobes are low, both data outputs are zero and the window count is empty. Cycles in which `adc_vld_i` is low have no effect on the outputs or on the window.
- R10: A full-scale window at the largest N, with every error at +(2^ADC_W - 1) or every error at -(2^ADC_W - 1), averages to exactly that error, with no accumulator overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| adc_i | input | ADC_W | Output-voltage sample, unsigned |
| adc_vld_i | input | 1 | Sample valid strobe |
| ref_i | input | ADC_W | Target voltage in ADC codes |
| dec_sel_i | input | SEL_W | log2 of the averaging window length |
| dz_thr_i | input | ADC_W | Dead-band half width in ADC codes |
| gain_i | input | GAIN_W | Fast-path gain, unsigned |
| avg_o | output | ADC_W+1 | Window-mean error, signed |
| avg_vld_o | output | 1 | Window mean valid |
| corr_o | output | OUT_W | Off-time correction, signed |
| corr_vld_o | output | 1 | Correction valid |

## Verification
The bench builds the block with its defaults: a 12-bit ADC word, windows of up to 16 samples, an 8-bit gain and a 16-bit correction. With these values, a full-scale error times the largest gain is far above the 16-bit range, so clipping at both limits can be reached from ordinary samples. The 16-sample window, filled with full-scale errors of either sign, exercises the widest accumulator sum. Because the shift limit is 4, a setting of 5 to 7 reaches the clamp.

// File: rtl/dvp_pkg.sv
package dvp_pkg;
  localparam int unsigned DEF_ADC_W     = 12;
  localparam int unsigned DEF_LOG2N_MAX = 4;
  localparam int unsigned DEF_GAIN_W    = 8;
  localparam int unsigned DEF_OUT_W     = 16;

  function automatic int unsigned sel_width(int unsigned log2n_max);
    return (log2n_max < 1) ? 1 : $clog2(log2n_max + 1);
  endfunction
endpackage

// File: rtl/dvp_err_sub.sv
module dvp_err_sub #(
  parameter int unsigned ADC_W = 12,
  localparam int unsigned ERR_W = ADC_W + 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [ADC_W-1:0]        adc_i,
  input  logic                    adc_vld_i,
  input  logic [ADC_W-1:0]        ref_i,
  output logic signed [ERR_W-1:0] err_o,
  output logic                    err_vld_o
);
  logic signed [ERR_W-1:0] diff;
  assign diff = $signed({1'b0, ref_i}) - $signed({1'b0, adc_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_o     <= '0;
      err_vld_o <= 1'b0;
    end else begin
      err_vld_o <= adc_vld_i;
      if (adc_vld_i) err_o <= diff;
    end
  end

  p_err_vld_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_vld_i |=> err_vld_o);
  p_idle_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adc_vld_i |=> (!err_vld_o && $stable(err_o)));
endmodule

// File: rtl/dvp_avg_decim.sv
module dvp_avg_decim #(
  parameter int unsigned ERR_W     = 13,
  parameter int unsigned LOG2N_MAX = 4,
  localparam int unsigned SEL_W    = dvp_pkg::sel_width(LOG2N_MAX),
  localparam int unsigned ACC_W    = ERR_W + LOG2N_MAX,
  localparam int unsigned CNT_W    = LOG2N_MAX + 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic signed [ERR_W-1:0] err_i,
  input  logic                    err_vld_i,
  input  logic [SEL_W-1:0]        dec_sel_i,
  output logic signed [ERR_W-1:0] avg_o,
  output logic                    avg_vld_o
);
  logic [SEL_W-1:0]        sel_clamp, sel_q, win_sel;
  logic [CNT_W-1:0]        cnt_q, last_cnt;
  logic signed [ACC_W-1:0] acc_q, acc_nxt, shifted;
  logic                    last;

  assign sel_clamp = (dec_sel_i > SEL_W'(LOG2N_MAX)) ? SEL_W'(LOG2N_MAX) : dec_sel_i;
  // setting is latched with the first sample of a window
  assign win_sel   = (cnt_q == '0) ? sel_clamp : sel_q;
  assign last_cnt  = (CNT_W'(1) << win_sel) - CNT_W'(1);
  assign last      = (cnt_q == last_cnt);
  assign acc_nxt   = acc_q + ACC_W'(err_i);
  assign shifted   = acc_nxt >>> win_sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q     <= '0;
      cnt_q     <= '0;
      sel_q     <= '0;
      avg_o     <= '0;
      avg_vld_o <= 1'b0;
    end else begin
      avg_vld_o <= 1'b0;
      if (err_vld_i) begin
        if (cnt_q == '0) sel_q <= sel_clamp;
        if (last) begin
          avg_o     <= shifted[ERR_W-1:0];
          avg_vld_o <= 1'b1;
          acc_q     <= '0;
          cnt_q     <= '0;
        end else begin
          acc_q <= acc_nxt;
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

  p_avg_needs_sample_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    avg_vld_o |-> $past(err_vld_i));
  p_sel_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0) |=> $stable(sel_q));
  p_win_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0) |-> (sel_q <= SEL_W'(LOG2N_MAX)));
  p_idle_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !err_vld_i |=> ($stable(cnt_q) && $stable(acc_q) && !avg_vld_o));
endmodule

// File: rtl/dvp_dz_gain.sv
module dvp_dz_gain #(
  parameter int unsigned ADC_W  = 12,
  parameter int unsigned GAIN_W = 8,
  parameter int unsigned OUT_W  = 16,
  localparam int unsigned ERR_W  = ADC_W + 1,
  localparam int unsigned PROD_W = ERR_W + GAIN_W + 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic signed [ERR_W-1:0] err_i,
  input  logic                    err_vld_i,
  input  logic [ADC_W-1:0]        thr_i,
  input  logic [GAIN_W-1:0]       gain_i,
  output logic signed [OUT_W-1:0] corr_o,
  output logic                    corr_vld_o
);
  logic signed [ERR_W:0]    err_x, thr_s;
  logic signed [PROD_W-1:0] err_p, gain_p, prod;
  logic signed [OUT_W-1:0]  sat;
  logic                     in_dz;

  assign err_x  = {err_i[ERR_W-1], err_i};
  assign thr_s  = {2'b00, thr_i};
  assign in_dz  = (err_x <= thr_s) && (err_x >= -thr_s);
  assign err_p  = {{(PROD_W-ERR_W){err_i[ERR_W-1]}}, err_i};
  assign gain_p = {{(PROD_W-GAIN_W){1'b0}}, gain_i};
  assign prod   = err_p * gain_p;

  generate
    if (PROD_W > OUT_W) begin : g_sat
      localparam logic signed [PROD_W-1:0] MAX_V = {{(PROD_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
      localparam logic signed [PROD_W-1:0] MIN_V = {{(PROD_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};
      always_comb begin
        if (prod > MAX_V)      sat = MAX_V[OUT_W-1:0];
        else if (prod < MIN_V) sat = MIN_V[OUT_W-1:0];
        else                   sat = prod[OUT_W-1:0];
      end
    end else begin : g_ext
      assign sat = OUT_W'(prod);
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      corr_o     <= '0;
      corr_vld_o <= 1'b0;
    end else begin
      corr_vld_o <= err_vld_i;
      if (err_vld_i) corr_o <= in_dz ? '0 : sat;
    end
  end

  p_full_rate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_vld_i |=> corr_vld_o);
  p_dead_band_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_vld_i && (err_x <= thr_s) && (err_x >= -thr_s)) |=> (corr_o == '0));
  p_no_wrap_pos_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_vld_i && !err_i[ERR_W-1]) |=> !corr_o[OUT_W-1]);
  p_no_wrap_neg_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_vld_i && err_i[ERR_W-1]) |=> (corr_o[OUT_W-1] || corr_o == '0));
endmodule

// File: rtl/dual_err_proc.sv
module dual_err_proc #(
  parameter int unsigned ADC_W     = dvp_pkg::DEF_ADC_W,
  parameter int unsigned LOG2N_MAX = dvp_pkg::DEF_LOG2N_MAX,
  parameter int unsigned GAIN_W    = dvp_pkg::DEF_GAIN_W,
  parameter int unsigned OUT_W     = dvp_pkg::DEF_OUT_W,
  localparam int unsigned ERR_W    = ADC_W + 1,
  localparam int unsigned SEL_W    = dvp_pkg::sel_width(LOG2N_MAX)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [ADC_W-1:0]        adc_i,
  input  logic                    adc_vld_i,
  input  logic [ADC_W-1:0]        ref_i,
  input  logic [SEL_W-1:0]        dec_sel_i,
  input  logic [ADC_W-1:0]        dz_thr_i,
  input  logic [GAIN_W-1:0]       gain_i,
  output logic signed [ERR_W-1:0] avg_o,
  output logic                    avg_vld_o,
  output logic signed [OUT_W-1:0] corr_o,
  output logic                    corr_vld_o
);
  logic signed [ERR_W-1:0] err;
  logic                    err_vld;

  dvp_err_sub #(.ADC_W(ADC_W)) u_sub (
    .clk_i, .rst_ni, .adc_i, .adc_vld_i, .ref_i,
    .err_o(err), .err_vld_o(err_vld)
  );

  dvp_avg_decim #(.ERR_W(ERR_W), .LOG2N_MAX(LOG2N_MAX)) u_avg (
    .clk_i, .rst_ni, .err_i(err), .err_vld_i(err_vld), .dec_sel_i,
    .avg_o, .avg_vld_o
  );

  dvp_dz_gain #(.ADC_W(ADC_W), .GAIN_W(GAIN_W), .OUT_W(OUT_W)) u_fast (
    .clk_i, .rst_ni, .err_i(err), .err_vld_i(err_vld), .thr_i(dz_thr_i),
    .gain_i, .corr_o, .corr_vld_o
  );

  p_paths_aligned_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    avg_vld_o |-> corr_vld_o);
endmodule

// File: tb/dual_err_proc_tb_top.sv
module dual_err_proc_tb_top;
  localparam int ADC_W = 12, LOG2N_MAX = 4, GAIN_W = 8, OUT_W = 16;
  localparam int ERR_W = ADC_W + 1, SEL_W = 3;
  localparam longint OMAX = (64'sd1 <<< (OUT_W-1)) - 1;
  localparam longint OMIN = -(64'sd1 <<< (OUT_W-1));

  logic clk = 1'b0, rst_n = 1'b0;
  logic [ADC_W-1:0] adc = '0, ref_w = '0, thr = '0;
  logic adc_vld = 1'b0;
  logic [SEL_W-1:0] sel = '0;
  logic [GAIN_W-1:0] gain = '0;
  logic signed [ERR_W-1:0] avg;
  logic avg_vld, corr_vld;
  logic signed [OUT_W-1:0] corr;

  int checks = 0, errors = 0;
  int m_cnt = 0, m_sel = 0;
  longint m_sum = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dual_err_proc dut_i (
    .clk_i(clk), .rst_ni(rst_n), .adc_i(adc), .adc_vld_i(adc_vld), .ref_i(ref_w),
    .dec_sel_i(sel), .dz_thr_i(thr), .gain_i(gain), .avg_o(avg), .avg_vld_o(avg_vld),
    .corr_o(corr), .corr_vld_o(corr_vld)
  );

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint exp_corr(longint e, longint t, longint g);
    longint p;
    if (e <= t && e >= -t) return 0;
    p = e * g;
    if (p > OMAX) return OMAX;
    if (p < OMIN) return OMIN;
    return p;
  endfunction

  // drive one sample, check both paths two edges later
  task automatic send(int r, int a, int s, int t, int g);
    longint e, ec;
    bit wv;
    longint wa;
    int ss;
    @(negedge clk);
    ref_w = r[ADC_W-1:0]; adc = a[ADC_W-1:0]; sel = s[SEL_W-1:0];
    thr = t[ADC_W-1:0]; gain = g[GAIN_W-1:0]; adc_vld = 1'b1;
    e = longint'(r) - longint'(a);   // R1
    if (m_cnt == 0) begin
      ss = s;
      m_sel = (ss > LOG2N_MAX) ? LOG2N_MAX : ss;
    end
    m_sum += e; m_cnt++;
    wv = (m_cnt == (1 << m_sel));
    wa = m_sum >>> m_sel;
    if (wv) begin m_cnt = 0; m_sum = 0; end
    ec = exp_corr(e, t, g);
    @(negedge clk);
    adc_vld = 1'b0;
    @(negedge clk);
    chk(corr_vld == 1'b1, "R5 corr_vld", longint'(corr_vld), 1);
    chk(longint'(corr) == ec, "R6/R7/R8 corr", longint'(corr), ec);
    chk(avg_vld == wv, "R3 avg_vld", longint'(avg_vld), longint'(wv));
    if (wv) chk(longint'(avg) == wa, "R2 avg", longint'(avg), wa);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(avg_vld == 0 && corr_vld == 0, "R9 reset strobes", longint'(avg_vld) + longint'(corr_vld), 0);
    chk(avg == 0 && corr == 0, "R9 reset data", longint'(avg) + longint'(corr), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R7: sign and gain, N=1
    send(1000, 900, 0, 0, 3);
    send(900, 1000, 0, 0, 3);
    // R6 dead band edges
    send(1000, 995, 0, 5, 10);
    send(1000, 1005, 0, 5, 10);
    send(1000, 994, 0, 5, 10);
    send(1000, 1006, 0, 5, 10);
    // R8 clipping both ways
    send(4095, 0, 0, 0, 255);
    send(0, 4095, 0, 0, 255);
    // R2 floor on negative mean, N=2: (-1 + 0) >>> 1 = -1
    send(100, 101, 1, 0, 1);
    send(100, 100, 1, 0, 1);

    // R9 idle cycles with noisy inputs: no strobes, window untouched
    send(500, 490, 2, 0, 1);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      adc = 12'($urandom); ref_w = 12'($urandom);
      @(negedge clk);
      chk(!avg_vld && !corr_vld, "R9 idle", longint'(avg_vld) + longint'(corr_vld), 0);
    end
    // R4 change selection mid-window: window stays 4 long
    send(500, 480, 0, 0, 1);
    send(500, 470, 0, 0, 1);
    send(500, 460, 0, 0, 1);

    // R10 full-scale windows at largest N
    for (int i = 0; i < 16; i++) send(4095, 0, 4, 0, 1);
    for (int i = 0; i < 16; i++) send(0, 4095, 4, 0, 1);
    // R2 clamp of over-range setting to largest N
    for (int i = 0; i < 16; i++) send(2000, 1990 + i, 7, 0, 1);

    // random mix
    for (int i = 0; i < 600; i++) begin
      int r, a;
      r = int'($urandom_range(4095));
      a = (i % 3 == 0) ? int'($urandom_range(4095))
                       : ((r + int'($urandom_range(40)) - 20) & 12'hfff);
      send(r, a, int'($urandom_range(7)), int'($urandom_range(15)), int'($urandom_range(255)));
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule